// File: doc/BRIEF.md
# CORDIC Gain Corrector with Saturating Doubler

A rotation engine built from shift-add micro-rotations grows the magnitude of its vector by a fixed factor. This block takes the two signed coordinates that leave such an engine and removes that growth. Each coordinate is multiplied by a fixed unsigned 32-bit fraction, 0xDBD95B16, which is about 0.858785. The 32 fractional bits of the product are then discarded with an arithmetic shift, which rounds toward minus infinity. Finally the value is doubled. If the doubled value does not fit in the output width, it is clamped to the nearest signed full-scale limit.

The two coordinates, called lanes, pass through identical four-register pipelines that share one clock enable. A pair presented together therefore leaves together. The sample width is a parameter and is 16 bits by default. Inputs and outputs have the same width. The block has no handshake: a sample is taken on each clock edge where the enable is high, and its result appears after exactly four such edges.

Top module: `cordic_gain_sat`

## Requirements
- R1: A rising clock edge with `rst_n` low sets `x_out` and `y_out` to 0 and clears every pipeline register. This happens whatever the value of `en`.
- R2: When no clamping is needed, each output equals 2*floor(s*0xDBD95B16 / 2^32). Here s is the signed input sample and the constant is read as an unsigned 32-bit integer.
- R3: When 2*floor(s*0xDBD95B16 / 2^32) exceeds 2^(SW-1)-1, the output is 2^(SW-1)-1 (32767 for SW=16).
- R4: When 2*floor(s*0xDBD95B16 / 2^32) is below -2^(SW-1), the output is -2^(SW-1) (-32768 for SW=16).
- R5: A sample taken on an enabled edge appears at the output after the fourth enabled edge, counting that edge as the first. The x and y results of one input pair appear at the same edge.
- R6: An edge with `en` low changes no register: the outputs hold, and the pipeline resumes with the same contents when `en` returns high.
- R7: The x and y lanes apply the same function independently. The result on one lane does not depend on the data on the other lane.
- R8: A zero input gives a zero output, and a negative input never gives a non-negative output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Clock enable; when high, every pipeline register advances |
| x_in | input | SW | Signed x sample to correct |
| y_in | input | SW | Signed y sample to correct |
| x_out | output | SW | Signed corrected and doubled x |
| y_out | output | SW | Signed corrected and doubled y |

## Verification
Directed samples are placed on both sides of the clamping threshold, near input 19078, so that a wrong overflow test shows up as a clamped value where a doubled one is expected, or the reverse. The signed full-scale extremes, zero and ±1 separate floor behaviour from truncation toward zero and catch a constant mistakenly read as signed. Seeded random pairs carry different data on x and y, which exposes swapped or coupled lanes. Random enable gaps and a lone impulse sample pin the latency to four enabled edges, and a reset in mid-stream shows that the outputs clear without an enable.

// File: rtl/gc_pkg.sv
// Package gc_pkg
// Holds the constants and types shared by the gain-correction pipeline:
// the correction fraction, its width and the lane count.
// Assumes the fraction is below 1.0, so a corrected sample always fits
// the sample width before the doubling step.
package gc_pkg;
    localparam int          GAIN_W    = 32;
    localparam logic [31:0] GAIN_FRAC = 32'hDBD95B16;
    localparam int          NUM_LANES = 2;

    typedef enum logic [0:0] {
        LANE_X = 1'b0,
        LANE_Y = 1'b1
    } lane_e;
endpackage

// File: rtl/gc_mul_stage.sv
// Module gc_mul_stage
// First pipeline step. Multiplies a signed sample by the unsigned gain
// fraction and registers the full product.
// Assumes the fraction is unsigned, so it is widened with a zero sign bit
// before the signed multiply. The product width SW+GW+1 cannot overflow.
module gc_mul_stage #(
    parameter int          SW   = 16,
    parameter int          GW   = 32,
    parameter logic [GW-1:0] FRAC = '0,
    localparam int         PW   = SW + GW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [SW-1:0] sample,
    output logic signed [PW-1:0] prod
);
    localparam logic signed [GW:0] FRAC_S = $signed({1'b0, FRAC});

    logic signed [PW-1:0] prod_d;

    // Full-width signed multiply of the sample by the positive fraction.
    always_comb begin
        prod_d = PW'(sample) * PW'(FRAC_S);
    end

    // Product register; advances only on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
        end else if (en) begin
            prod <= prod_d;
        end
    end
endmodule

// File: rtl/gc_frac_drop.sv
// Module gc_frac_drop
// Second pipeline step. Discards the GW fractional bits of the product with
// an arithmetic shift, which floors toward minus infinity.
// Assumes the input is a product from gc_mul_stage; the SW+1 integer bits
// are kept so that the next step can test for overflow.
module gc_frac_drop #(
    parameter int SW = 16,
    parameter int GW = 32,
    localparam int PW = SW + GW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [PW-1:0] prod,
    output logic signed [SW:0]   whole
);
    logic signed [SW:0]   whole_d;
    logic        [GW-1:0] frac_unused;

    // Keep the integer part of the product; the fraction is discarded.
    always_comb begin
        whole_d     = prod[PW-1:GW];
        frac_unused = prod[GW-1:0];
    end

    // Integer-part register; advances only on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            whole <= '0;
        end else if (en) begin
            whole <= whole_d;
        end
    end
endmodule

// File: rtl/gc_sat_double.sv
// Module gc_sat_double
// Third pipeline step. Doubles the corrected value and clamps it to the
// signed SW-bit range when the shift would overflow.
// Assumes an SW+1-bit signed input. The value fits SW bits after doubling
// only when its top three bits are equal; otherwise the sign bit decides
// which limit is used.
module gc_sat_double #(
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [SW:0]   whole,
    output logic signed [SW-1:0] dbl
);
    localparam logic signed [SW-1:0] POS_LIM = {1'b0, {(SW-1){1'b1}}};
    localparam logic signed [SW-1:0] NEG_LIM = {1'b1, {(SW-1){1'b0}}};

    logic                 ovf;
    logic signed [SW-1:0] dbl_d;

    // Overflow test on the top bits, then pick the limit or the shifted value.
    always_comb begin
        ovf = (whole[SW] != whole[SW-1]) || (whole[SW-1] != whole[SW-2]);
        if (ovf) begin
            dbl_d = whole[SW] ? NEG_LIM : POS_LIM;
        end else begin
            dbl_d = {whole[SW-2:0], 1'b0};
        end
    end

    // Doubled-value register; advances only on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl <= '0;
        end else if (en) begin
            dbl <= dbl_d;
        end
    end
endmodule

// File: rtl/gc_out_reg.sv
// Module gc_out_reg
// Fourth pipeline step. A plain enabled output register, so that the port
// is driven straight from a flop.
// Assumes its input is already in final form.
module gc_out_reg #(
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [SW-1:0] d,
    output logic signed [SW-1:0] q
);
    // Output register; advances only on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/gc_lane.sv
// Module gc_lane
// One full correction lane: multiply, drop fraction, saturating double and
// output register, in that order. Latency is four enabled edges.
// Assumes every stage shares the same enable, so that lanes stay aligned.
module gc_lane #(
    parameter int              SW   = 16,
    parameter int              GW   = 32,
    parameter logic [GW-1:0]   FRAC = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [SW-1:0] s_in,
    output logic signed [SW-1:0] s_out
);
    localparam int PW = SW + GW + 1;

    logic signed [PW-1:0] prod;
    logic signed [SW:0]   whole;
    logic signed [SW-1:0] dbl;

    gc_mul_stage #(.SW(SW), .GW(GW), .FRAC(FRAC)) u_mul (
        .clk(clk), .rst_n(rst_n), .en(en), .sample(s_in), .prod(prod)
    );

    gc_frac_drop #(.SW(SW), .GW(GW)) u_frac (
        .clk(clk), .rst_n(rst_n), .en(en), .prod(prod), .whole(whole)
    );

    gc_sat_double #(.SW(SW)) u_sat (
        .clk(clk), .rst_n(rst_n), .en(en), .whole(whole), .dbl(dbl)
    );

    gc_out_reg #(.SW(SW)) u_out (
        .clk(clk), .rst_n(rst_n), .en(en), .d(dbl), .q(s_out)
    );
endmodule

// File: rtl/cordic_gain_sat.sv
// Module cordic_gain_sat
// Removes the CORDIC magnitude gain from an x/y pair and doubles the result
// with saturation. The two lanes are identical pipelines, built by a
// generate loop, that share the clock enable.
// Assumes SW >= 3, so that the overflow test has three bits to inspect.
module cordic_gain_sat #(
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [SW-1:0] x_in,
    input  logic signed [SW-1:0] y_in,
    output logic signed [SW-1:0] x_out,
    output logic signed [SW-1:0] y_out
);
    import gc_pkg::*;

    logic signed [SW-1:0] lane_in  [NUM_LANES];
    logic signed [SW-1:0] lane_out [NUM_LANES];

    // Route the ports onto the lane arrays.
    always_comb begin
        lane_in[LANE_X] = x_in;
        lane_in[LANE_Y] = y_in;
        x_out           = lane_out[LANE_X];
        y_out           = lane_out[LANE_Y];
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        gc_lane #(.SW(SW), .GW(GAIN_W), .FRAC(GAIN_FRAC)) u_lane (
            .clk(clk), .rst_n(rst_n), .en(en),
            .s_in(lane_in[g]), .s_out(lane_out[g])
        );
    end
endmodule

// File: rtl/cordic_gain_sat_chk.sv
// Module cordic_gain_sat_chk
// Port-level checker bound to cordic_gain_sat. It keeps a four-deep record
// of input classes, advanced on enabled edges, and compares the outputs
// with that record.
// Assumes the fraction lies between 0.75 and 1.0.
module cordic_gain_sat_chk #(
    parameter int SW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic signed [SW-1:0] x_in,
    input logic signed [SW-1:0] y_in,
    input logic signed [SW-1:0] x_out,
    input logic signed [SW-1:0] y_out
);
    localparam int LAT = 4;
    localparam logic signed [SW-1:0] POS_LIM = {1'b0, {(SW-1){1'b1}}};
    localparam logic signed [SW-1:0] NEG_LIM = {1'b1, {(SW-1){1'b0}}};
    localparam logic signed [SW-1:0] BIG_POS = {2'b01, {(SW-2){1'b1}}} - (SW'(1) <<< (SW-3)) + SW'(1);
    localparam logic signed [SW-1:0] BIG_NEG = -BIG_POS;

    // class codes: 0 zero, 1 positive, 2 negative, 3 large positive, 4 large negative
    logic [2:0] cls_x [LAT];
    logic [2:0] cls_y [LAT];
    logic [2:0] fill;

    function automatic logic [2:0] classify(input logic signed [SW-1:0] s);
        if (s == 0)             return 3'd0;
        else if (s >= BIG_POS)  return 3'd3;
        else if (s <= BIG_NEG)  return 3'd4;
        else if (s > 0)         return 3'd1;
        else                    return 3'd2;
    endfunction

    // Shift the class record on enabled edges; count fill up to LAT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
            for (int i = 0; i < LAT; i++) begin
                cls_x[i] <= '0;
                cls_y[i] <= '0;
            end
        end else if (en) begin
            cls_x[0] <= classify(x_in);
            cls_y[0] <= classify(y_in);
            for (int i = 1; i < LAT; i++) begin
                cls_x[i] <= cls_x[i-1];
                cls_y[i] <= cls_y[i-1];
            end
            if (fill < 3'(LAT)) fill <= fill + 3'd1;
        end
    end

    logic full;
    assign full = (fill == 3'(LAT));

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (x_out == 0 && y_out == 0));

    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(x_out) && $stable(y_out)));

    a_r2_even_or_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (x_out[0] == 1'b0 || x_out == POS_LIM) && (y_out[0] == 1'b0 || y_out == POS_LIM));

    a_r8_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cls_x[LAT-1] == 3'd0) |-> (x_out == 0));

    a_r8_negative_stays_negative: assert property (@(posedge clk) disable iff (!rst_n)
        (full && (cls_y[LAT-1] == 3'd2 || cls_y[LAT-1] == 3'd4)) |-> (y_out < 0));

    a_r3_large_positive_clamps: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cls_x[LAT-1] == 3'd3) |-> (x_out == POS_LIM));

    a_r4_large_negative_clamps: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cls_y[LAT-1] == 3'd4) |-> (y_out == NEG_LIM));
endmodule

bind cordic_gain_sat cordic_gain_sat_chk #(.SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en),
    .x_in(x_in), .y_in(y_in), .x_out(x_out), .y_out(y_out)
);

// File: tb/tb_cordic_gain_sat.sv
`timescale 1ns/1ps
module tb_cordic_gain_sat;
    localparam int SW = 16;
    localparam int MAXN = 4096;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en = 1'b0;
    logic signed [SW-1:0] x_in = '0;
    logic signed [SW-1:0] y_in = '0;
    logic signed [SW-1:0] x_out;
    logic signed [SW-1:0] y_out;

    int checks = 0;
    int fails  = 0;
    int n_en   = 0;
    int hx [MAXN];
    int hy [MAXN];
    bit finished = 0;

    always #2.5 clk = ~clk;

    cordic_gain_sat #(.SW(SW)) dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .x_in(x_in), .y_in(y_in), .x_out(x_out), .y_out(y_out)
    );

    // Unclamped result: 2*floor(s*K/2^32).
    function automatic longint raw_dbl(input int s);
        longint p;
        p = longint'(s) * longint'(64'hDBD95B16);
        return (p >>> 32) * 2;
    endfunction

    function automatic int expect_of(input int s);
        longint d;
        d = raw_dbl(s);
        if (d > 32767)  return 32767;
        if (d < -32768) return -32768;
        return int'(d);
    endfunction

    function automatic string tag_of(input int s);
        longint d;
        d = raw_dbl(s);
        if (d > 32767)  return "R3";
        if (d < -32768) return "R4";
        if (s == 0)     return "R8";
        return "R2";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Outputs predicted from the enabled-edge history (R5 latency of 4).
    task automatic check_model(input string lane_note);
        int ex, ey;
        if (n_en >= 4) begin
            ex = expect_of(hx[n_en-4]);
            ey = expect_of(hy[n_en-4]);
            check({tag_of(hx[n_en-4]), " R5 R7 x ", lane_note}, int'(x_out), ex);
            check({tag_of(hy[n_en-4]), " R5 R7 y ", lane_note}, int'(y_out), ey);
        end else begin
            check({"R5 fill x ", lane_note}, int'(x_out), 0);
            check({"R5 fill y ", lane_note}, int'(y_out), 0);
        end
    endtask

    // One cycle: drive at negedge, let the edge happen, check at next negedge.
    task automatic step(input int xv, input int yv, input bit e);
        x_in = SW'(xv);
        y_in = SW'(yv);
        en   = e;
        @(posedge clk);
        if (e && rst_n && n_en < MAXN) begin
            hx[n_en] = xv;
            hy[n_en] = yv;
            n_en++;
        end
        @(negedge clk);
        check_model("stream");
    endtask

    initial begin : main
        int dir [14];
        int px, py;
        void'($urandom(32'd20240611));
        dir = '{32767, -32768, 0, 1, -1, 19078, 19079, -19078, -19079,
                24576, -24576, 16384, -16384, 12345};

        // R1: reset with en low clears outputs
        rst_n = 1'b0; en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset x", int'(x_out), 0);
        check("R1 reset y", int'(y_out), 0);
        rst_n = 1'b1;

        // R5: lone impulse, visible only after the fourth enabled edge
        step(32767, -32768, 1'b1);
        step(0, 0, 1'b1);
        step(0, 0, 1'b1);
        check("R5 not yet at edge 3 x", int'(x_out), 0);
        step(0, 0, 1'b1);
        check("R5 at edge 4 x", int'(x_out), 32767);
        check("R5 at edge 4 y", int'(y_out), -32768);

        // Directed corners, with x and y carrying different data (R7)
        foreach (dir[i]) step(dir[i], dir[(i + 5) % 14], 1'b1);
        for (int i = 0; i < 4; i++) step(0, 0, 1'b1);

        // R6: stall keeps outputs and resumes the same stream
        step(-20000, 30000, 1'b1);
        step(5000, -7000, 1'b1);
        px = int'(x_out); py = int'(y_out);
        for (int i = 0; i < 5; i++) begin
            step($urandom_range(65535) - 32768, $urandom_range(65535) - 32768, 1'b0);
            check("R6 hold x", int'(x_out), px);
            check("R6 hold y", int'(y_out), py);
        end
        for (int i = 0; i < 4; i++) step(0, 0, 1'b1);

        // Random stream with random enable gaps
        for (int i = 0; i < 600; i++) begin
            step($urandom_range(65535) - 32768, $urandom_range(65535) - 32768,
                 ($urandom_range(3) != 0));
        end

        // R1: reset in mid-stream with en low
        step(1000, -1000, 1'b1);
        rst_n = 1'b0;
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 midstream x", int'(x_out), 0);
        check("R1 midstream y", int'(y_out), 0);
        rst_n = 1'b1;
        n_en = 0;
        for (int i = 0; i < 6; i++) step(-3000 * i, 3000 * i, 1'b1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule